// File: doc/BRIEF.md
# Stack Frame Chain Walker

This block unwinds a call stack in hardware. Software, or a debug agent, hands it the current frame pointer together with a depth limit. The walker then follows the chain of activation records held in word-addressed memory.

Each record has a fixed layout. The frame pointer addresses the record's top word, which holds the saved program counter. The saved return link sits one word (4 bytes) below it. The saved caller frame pointer sits four words (16 bytes) below it. Every frame keeps the caller pointer at the same offset, so the saved pointers form a singly linked list that ends in a zero pointer.

For every frame the walker reads the link word and then the caller pointer over a synchronous read port with a fixed one-cycle latency. It offers a record (the frame address and the cleaned link value) on a valid/ready output, and only after that record is taken does it move to the caller frame. The walk ends at a null pointer, at a corrupt pointer, or when the depth limit is used up. In every case a one-cycle done pulse reports the number of frames emitted and whether the walk ended in error.

Top module: `frame_chain_walker`

## Requirements
- R1: After reset `busy`, `done`, `walkErr`, `recValid` and `memReq` are all low.
- R2: For each frame at pointer F, the block issues exactly two reads, in this order: first address F-4, then address F-16. Every read address has bits 1:0 equal to 0. Read data is taken from `memRdata` one cycle after the cycle in which `memReq` was high.
- R3: Each record carries `recFrame` = F and `recLink` = the word read at F-4 with bits 1:0 forced to 0. Records appear in chain order, starting with the start pointer.
- R4: While `recValid` is high and `recReady` is low, the record is held unchanged and no read is issued. The caller pointer is followed only after the record is accepted.
- R5: A pointer of zero (the start pointer or a caller pointer) ends the walk. `done` then rises with `walkErr`=0 and `frameCount` equal to the number of records accepted. A start pointer of zero gives a count of 0.
- R6: A non-zero pointer whose bits 1:0 are not 00 ends the walk with `walkErr`=1 and no further record. This applies to the start pointer as well as to caller pointers.
- R7: A non-zero caller pointer that is not strictly greater than the frame it was read from ends the walk with `walkErr`=1. Chains that loop back are caught this way.
- R8: If `depthLimit` records have been accepted and the next pointer is non-zero and well formed, the walk ends with `walkErr`=1. The null check takes priority, so a chain of exactly `depthLimit` frames ends without error. A limit of 0 with a non-zero start pointer gives an error and a count of 0.
- R9: `done` is high for exactly one cycle per walk, with `busy` high and `recValid` low in that cycle. `busy` is high from the cycle after the start is accepted through the `done` cycle.
- R10: `startValid` is accepted only while `busy` is low. A start strobe while busy has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start strobe, sampled while idle |
| startFp | input | 32 | Frame pointer where the walk begins |
| depthLimit | input | 16 | Maximum number of records to emit |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| walkErr | output | 1 | Error flag, valid with `done` |
| frameCount | output | 16 | Number of records accepted, valid with `done` |
| memReq | output | 1 | Read request |
| memAddr | output | 32 | Byte address of the read |
| memRdata | input | 32 | Read data, one cycle after the request |
| recValid | output | 1 | Record available |
| recReady | input | 1 | Record accepted when high with `recValid` |
| recFrame | output | 32 | Frame address of the record |
| recLink | output | 32 | Saved link value, bits 1:0 cleared |

## Verification
Two functions of the block can fall in the same cycle: record acceptance and the termination check on the pointer it exposes. The depth limit, the null test and the ordering test all look at the values that the accepting handshake has just loaded. The bench builds chains whose length equals the limit and is one more than the limit. It also builds chains that end in a loop or in a misaligned pointer, and it runs them with back-pressure so that acceptance lands on different cycles. A walk passes only if the record list, the read order, the error flag and the frame count reported with `done` all match the values worked out from the chain layout.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadStart;  // latch start pointer and limit, clear counters
    logic capLink;    // capture read data as saved link
    logic capNext;    // capture read data as caller pointer
    logic advance;    // record accepted: step to caller frame
    logic selNext;    // read address selects the caller-pointer slot
  } fcwCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CHECK    = 3'd1,
    ST_LINK_REQ = 3'd2,
    ST_NEXT_REQ = 3'd3,
    ST_NEXT_CAP = 3'd4,
    ST_EMIT     = 3'd5,
    ST_FINISH   = 3'd6
  } fcwState_t;

endpackage

// File: rtl/fcw_datapath.sv
module fcw_datapath
  import fcw_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DEPTH_W        = 16,
  parameter int WORD_BYTES     = 4,
  parameter int LINK_OFS_WORDS = 1,
  parameter int NEXT_OFS_WORDS = 4,
  parameter bit MASK_LINK      = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  fcwCtrl_t           ctrl,
  input  logic [ADDR_W-1:0]  startFp,
  input  logic [DEPTH_W-1:0] depthLimit,
  input  logic [ADDR_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ADDR_W-1:0]  recFrame,
  output logic [ADDR_W-1:0]  recLink,
  output logic [DEPTH_W-1:0] frameCount,
  output logic               fpNull,
  output logic               fpBad,
  output logic               depthHit
);

  localparam int ALIGN_W = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] LINK_BYTES = ADDR_W'(LINK_OFS_WORDS * WORD_BYTES);
  localparam logic [ADDR_W-1:0] NEXT_BYTES = ADDR_W'(NEXT_OFS_WORDS * WORD_BYTES);

  logic [ADDR_W-1:0]  fpQ;
  logic [ADDR_W-1:0]  prevQ;
  logic [ADDR_W-1:0]  linkQ;
  logic [ADDR_W-1:0]  nextQ;
  logic [DEPTH_W-1:0] countQ;
  logic [DEPTH_W-1:0] limitQ;
  logic [ADDR_W-1:0]  linkClean;

  // Link value cleanup: low address bits of a saved PC carry no meaning
  generate
    if (MASK_LINK) begin : g_mask
      assign linkClean = {memRdata[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end else begin : g_raw
      assign linkClean = memRdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpQ    <= '0;
      prevQ  <= '0;
      linkQ  <= '0;
      nextQ  <= '0;
      countQ <= '0;
      limitQ <= '0;
    end else begin
      if (ctrl.loadStart) begin
        fpQ    <= startFp;
        prevQ  <= '0;
        countQ <= '0;
        limitQ <= depthLimit;
      end else if (ctrl.advance) begin
        prevQ  <= fpQ;
        fpQ    <= nextQ;
        countQ <= countQ + DEPTH_W'(1);
      end
      if (ctrl.capLink) linkQ <= linkClean;
      if (ctrl.capNext) nextQ <= memRdata;
    end
  end

  assign memAddr    = fpQ - (ctrl.selNext ? NEXT_BYTES : LINK_BYTES);
  assign recFrame   = fpQ;
  assign recLink    = linkQ;
  assign frameCount = countQ;

  // Termination tests on the pointer currently held
  assign fpNull   = (fpQ == '0);
  assign fpBad    = (fpQ[ALIGN_W-1:0] != '0) || (fpQ <= prevQ);
  assign depthHit = (countQ == limitQ);

endmodule

// File: rtl/fcw_ctrl.sv
module fcw_ctrl
  import fcw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startValid,
  input  logic     recReady,
  input  logic     fpNull,
  input  logic     fpBad,
  input  logic     depthHit,
  output fcwCtrl_t ctrl,
  output logic     memReq,
  output logic     recValid,
  output logic     busy,
  output logic     done,
  output logic     walkErr
);

  fcwState_t stQ, stNxt;
  logic      errQ, errNxt;

  always_comb begin
    stNxt    = stQ;
    errNxt   = errQ;
    ctrl     = '0;
    memReq   = 1'b0;
    recValid = 1'b0;
    case (stQ)
      ST_IDLE: begin
        if (startValid) begin
          ctrl.loadStart = 1'b1;
          errNxt         = 1'b0;
          stNxt          = ST_CHECK;
        end
      end
      ST_CHECK: begin
        // null wins over every other test
        if (fpNull) begin
          errNxt = 1'b0;
          stNxt  = ST_FINISH;
        end else if (fpBad || depthHit) begin
          errNxt = 1'b1;
          stNxt  = ST_FINISH;
        end else begin
          stNxt = ST_LINK_REQ;
        end
      end
      ST_LINK_REQ: begin
        memReq       = 1'b1;
        ctrl.selNext = 1'b0;
        stNxt        = ST_NEXT_REQ;
      end
      ST_NEXT_REQ: begin
        ctrl.capLink = 1'b1;
        memReq       = 1'b1;
        ctrl.selNext = 1'b1;
        stNxt        = ST_NEXT_CAP;
      end
      ST_NEXT_CAP: begin
        ctrl.capNext = 1'b1;
        stNxt        = ST_EMIT;
      end
      ST_EMIT: begin
        recValid = 1'b1;
        if (recReady) begin
          ctrl.advance = 1'b1;
          stNxt        = ST_CHECK;
        end
      end
      ST_FINISH: stNxt = ST_IDLE;
      default:   stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      errQ <= 1'b0;
    end else begin
      stQ  <= stNxt;
      errQ <= errNxt;
    end
  end

  assign busy    = (stQ != ST_IDLE);
  assign done    = (stQ == ST_FINISH);
  assign walkErr = done & errQ;

endmodule

// File: rtl/frame_chain_walker.sv
module frame_chain_walker
  import fcw_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DEPTH_W        = 16,
  parameter int WORD_BYTES     = 4,
  parameter int LINK_OFS_WORDS = 1,
  parameter int NEXT_OFS_WORDS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [ADDR_W-1:0]  startFp,
  input  logic [DEPTH_W-1:0] depthLimit,
  output logic               busy,
  output logic               done,
  output logic               walkErr,
  output logic [DEPTH_W-1:0] frameCount,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [ADDR_W-1:0]  memRdata,
  output logic               recValid,
  input  logic               recReady,
  output logic [ADDR_W-1:0]  recFrame,
  output logic [ADDR_W-1:0]  recLink
);

  fcwCtrl_t ctrl;
  logic     fpNull, fpBad, depthHit;

  fcw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .recReady   (recReady),
    .fpNull     (fpNull),
    .fpBad      (fpBad),
    .depthHit   (depthHit),
    .ctrl       (ctrl),
    .memReq     (memReq),
    .recValid   (recValid),
    .busy       (busy),
    .done       (done),
    .walkErr    (walkErr)
  );

  fcw_datapath #(
    .ADDR_W         (ADDR_W),
    .DEPTH_W        (DEPTH_W),
    .WORD_BYTES     (WORD_BYTES),
    .LINK_OFS_WORDS (LINK_OFS_WORDS),
    .NEXT_OFS_WORDS (NEXT_OFS_WORDS),
    .MASK_LINK      (1'b1)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .startFp    (startFp),
    .depthLimit (depthLimit),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .recFrame   (recFrame),
    .recLink    (recLink),
    .frameCount (frameCount),
    .fpNull     (fpNull),
    .fpBad      (fpBad),
    .depthHit   (depthHit)
  );

endmodule

// File: rtl/fcw_checker.sv
module fcw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              recValid,
  input logic              recReady,
  input logic [ADDR_W-1:0] recFrame,
  input logic [ADDR_W-1:0] recLink
);

  p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  p_frame_ok_r3: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> (recFrame != '0) && (recFrame[1:0] == 2'b00));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recReady) |=> recValid && $stable(recFrame) && $stable(recLink));

  p_no_read_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> !memReq);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy && !recValid && !memReq);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && startValid) |=> busy);

endmodule

bind frame_chain_walker fcw_checker #(.ADDR_W(ADDR_W)) u_fcwChk (
  .clk        (clk),
  .rstN       (rstN),
  .startValid (startValid),
  .busy       (busy),
  .done       (done),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .recValid   (recValid),
  .recReady   (recReady),
  .recFrame   (recFrame),
  .recLink    (recLink)
);

// File: tb/sim_frame_chain_walker.sv
module sim_frame_chain_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] startFp = '0;
  logic [15:0] depthLimit = '0;
  logic        busy, done, walkErr, memReq, recValid;
  logic        recReady = 1'b0;
  logic [15:0] frameCount;
  logic [31:0] memAddr, recFrame, recLink;
  logic [31:0] memRdata = '0;

  logic [31:0] mem [0:255];

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] recF [0:15];
  logic [31:0] recL [0:15];
  logic [31:0] reqLog [0:31];
  int          nRec, nReq;
  logic        gotDone, dErr;
  logic [15:0] dCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_chain_walker u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startFp(startFp),
    .depthLimit(depthLimit), .busy(busy), .done(done), .walkErr(walkErr),
    .frameCount(frameCount), .memReq(memReq), .memAddr(memAddr),
    .memRdata(memRdata), .recValid(recValid), .recReady(recReady),
    .recFrame(recFrame), .recLink(recLink)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) if (memReq) memRdata <= mem[memAddr[9:2]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic setFrame(input logic [31:0] fp, input logic [31:0] lnk, input logic [31:0] nxt);
    mem[(fp - 32'd4) >> 2]  = lnk;
    mem[(fp - 32'd16) >> 2] = nxt;
  endtask

  // standard chain: 0x200 -> 0x280 -> 0x300 -> null
  task automatic chainA();
    clearMem();
    setFrame(32'h200, 32'h0000_1003, 32'h280);
    setFrame(32'h280, 32'h0000_2004, 32'h300);
    setFrame(32'h300, 32'h0000_3009, 32'h0);
  endtask

  task automatic runWalk(input logic [31:0] fp, input logic [15:0] lim,
                         input bit stall, input logic [31:0] intrudeFp);
    bit intruded = 1'b0;
    nRec = 0; nReq = 0; gotDone = 1'b0; dErr = 1'b0; dCnt = '0;
    @(negedge clk);
    startValid = 1'b1; startFp = fp; depthLimit = lim; recReady = 1'b0;
    @(negedge clk);
    startValid = 1'b0;
    for (int cyc = 0; cyc < 400 && !gotDone; cyc++) begin
      bit rdy;
      if (memReq && nReq < 32) begin reqLog[nReq] = memAddr; nReq++; end
      if (done) begin gotDone = 1'b1; dErr = walkErr; dCnt = frameCount; end
      rdy = stall ? ((cyc % 3) == 2) : 1'b1;
      recReady = rdy;
      if (recValid && rdy && nRec < 16) begin
        recF[nRec] = recFrame; recL[nRec] = recLink; nRec++;
      end
      if (intrudeFp != 0 && nRec == 1 && !intruded) begin
        startValid = 1'b1; startFp = intrudeFp; intruded = 1'b1;
      end else begin
        startValid = 1'b0;
      end
      @(negedge clk);
    end
    startValid = 1'b0;
    recReady = 1'b0;
    chk(gotDone, "watchdog: walk did not finish", {31'd0, gotDone}, 32'd1);
  endtask

  task automatic checkChainA(input string req);
    chk(nRec == 3, {req, " record count"}, nRec, 3);
    chk(recF[0] == 32'h200 && recF[1] == 32'h280 && recF[2] == 32'h300,
        {req, " frame order R3"}, recF[2], 32'h300);
    chk(recL[0] == 32'h1000 && recL[1] == 32'h2004 && recL[2] == 32'h3008,
        {req, " link masked R3"}, recL[0], 32'h1000);
    chk(dErr == 1'b0 && dCnt == 16'd3, {req, " null end R5"}, {dErr, 15'd0, dCnt}, 32'd3);
  endtask

  task automatic testReset();
    chk(!busy && !done && !walkErr && !recValid && !memReq, "R1 reset outputs",
        {27'd0, busy, done, walkErr, recValid, memReq}, 32'd0);
  endtask

  task automatic testBasic();
    chainA();
    runWalk(32'h200, 16'd10, 1'b0, 32'd0);
    checkChainA("basic");
    chk(nReq == 6, "R2 read count", nReq, 6);
    chk(reqLog[0] == 32'h1FC && reqLog[1] == 32'h1F0, "R2 first frame read order", reqLog[1], 32'h1F0);
    chk(reqLog[4] == 32'h2FC && reqLog[5] == 32'h2F0, "R2 last frame read order", reqLog[5], 32'h2F0);
    chk(!busy && !done, "R9 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  task automatic testStall();
    chainA();
    runWalk(32'h200, 16'd10, 1'b1, 32'd0);
    checkChainA("stall R4");
    chk(nReq == 6, "R4 no extra reads under stall", nReq, 6);
  endtask

  task automatic testNullStart();
    clearMem();
    runWalk(32'h0, 16'd5, 1'b0, 32'd0);
    chk(nRec == 0 && nReq == 0, "R5 null start no activity", nRec + nReq, 0);
    chk(!dErr && dCnt == 0, "R5 null start count", {dErr, 15'd0, dCnt}, 32'd0);
  endtask

  task automatic testMisaligned();
    clearMem();
    setFrame(32'h200, 32'h4000, 32'h282);
    runWalk(32'h200, 16'd10, 1'b0, 32'd0);
    chk(nRec == 1 && recF[0] == 32'h200, "R6 one record before bad ptr", nRec, 1);
    chk(dErr && dCnt == 1, "R6 misaligned next", {dErr, 15'd0, dCnt}, 32'h8000_0001);
    runWalk(32'h202, 16'd10, 1'b0, 32'd0);
    chk(nRec == 0 && nReq == 0 && dErr && dCnt == 0, "R6 misaligned start",
        {dErr, 15'd0, dCnt}, 32'h8000_0000);
  endtask

  task automatic testLoop();
    clearMem();
    setFrame(32'h200, 32'h100, 32'h280);
    setFrame(32'h280, 32'h104, 32'h200);
    runWalk(32'h200, 16'd10, 1'b0, 32'd0);
    chk(nRec == 2, "R7 records before loop", nRec, 2);
    chk(dErr && dCnt == 2, "R7 loop error", {dErr, 15'd0, dCnt}, 32'h8000_0002);
    clearMem();
    setFrame(32'h200, 32'h100, 32'h200);
    runWalk(32'h200, 16'd10, 1'b0, 32'd0);
    chk(dErr && dCnt == 1, "R7 self pointer error", {dErr, 15'd0, dCnt}, 32'h8000_0001);
  endtask

  task automatic testDepth();
    chainA();
    runWalk(32'h200, 16'd2, 1'b0, 32'd0);
    chk(nRec == 2 && dErr && dCnt == 2, "R8 limit below chain",
        {dErr, 15'd0, dCnt}, 32'h8000_0002);
    runWalk(32'h200, 16'd3, 1'b1, 32'd0);
    chk(nRec == 3 && !dErr && dCnt == 3, "R8 limit equals chain",
        {dErr, 15'd0, dCnt}, 32'd3);
    runWalk(32'h200, 16'd0, 1'b0, 32'd0);
    chk(nRec == 0 && dErr && dCnt == 0, "R8 zero limit",
        {dErr, 15'd0, dCnt}, 32'h8000_0000);
  endtask

  task automatic testIntrude();
    chainA();
    runWalk(32'h200, 16'd10, 1'b0, 32'h3C0);
    checkChainA("R10 start while busy");
    chk(nReq == 6, "R10 no reads from second start", nReq, 6);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testStall();
    testNullStart();
    testMisaligned();
    testLoop();
    testDepth();
    testIntrude();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule